// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Automatic Refresh

This controller sits between a simple requester and a DRAM device whose address pins are shared between row and column. Each accepted request is turned into one complete memory cycle. The row part of the address goes out first and the row strobe is raised. The column part then follows on the same pins and the column strobe is raised. For a read, the incoming data is captured once the column access time has run out. For a write, the write enable and the outgoing data are presented from the very first cycle of the access. Each access ends with a precharge gap in which both strobes are low.

An internal interval timer raises refresh work without any action from the requester. A refresh cycle raises only the row strobe, with a refresh row pointer on the address pins, and then advances that pointer. A pending refresh is served before a new request, but it never cuts into an access that has already started. All timing figures are parameters counted in clock cycles.

Top module: `mux_dram_ctrl`

## Requirements
- R1: The request address is split with the row in the upper ROW_W bits and the column in the lower COL_W bits. Each part is driven, zero-extended, on the shared `dram_addr_o` pins: the row while the row strobe rises, the column while the column strobe rises.
- R2: A user access first holds the row on the pins with `dram_ras_o` low for T_RSU cycles. It then raises `dram_ras_o` (active high) and keeps the row there. `dram_cas_o` rises exactly T_RCD cycles after `dram_ras_o` rises.
- R3: `dram_cas_o` (active high) stays high for T_CAC cycles, with the column on the pins. It is never high while `dram_ras_o` is low.
- R4: A read captures `dram_dq_i` at the clock edge that ends the T_CAC-th column-strobe cycle. The value is shown on `rsp_rdata_o` and held there until the next read completes.
- R5: For a write, `dram_we_o` and `dram_dq_oe_o` are high and `dram_dq_o` carries the write data from the first cycle after acceptance until the column strobe ends. `dram_we_o` is never high without `dram_dq_oe_o`.
- R6: After every cycle, both strobes stay low for at least T_PRE cycles before `dram_ras_o` rises again.
- R7: With no user traffic, a refresh starts every REF_INTERVAL cycles. A refresh raises only `dram_ras_o`, for T_RCD+T_CAC cycles, with no column strobe.
- R8: The refresh row starts at 0 after reset and advances by one per refresh, wrapping modulo 2^ROW_W.
- R9: `req_ready_o` is low while any cycle is in progress or a refresh is pending. A request is taken only in a cycle where `req_valid_i` and `req_ready_o` are both high. Refreshes keep occurring under back-to-back requests.
- R10: `rsp_done_o` is a one-cycle pulse for both reads and writes. It is seen T_RSU+T_RCD+T_CAC+1 cycles after the accepting edge.
- R11: During and right after reset, both strobes, the write enable, the data enable and the done pulse are low, and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_W+COL_W | Full word address, row in upper bits |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Request can be taken this cycle |
| rsp_rdata_o | output | DATA_W | Last read data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| dram_addr_o | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_ras_o | output | 1 | Row strobe, active high |
| dram_cas_o | output | 1 | Column strobe, active high |
| dram_we_o | output | 1 | Write enable, active high |
| dram_dq_o | output | DATA_W | Data toward memory |
| dram_dq_oe_o | output | 1 | Output enable for `dram_dq_o` |
| dram_dq_i | input | DATA_W | Data from memory |

## Verification
The assertions assume that T_RSU, T_RCD, T_CAC and T_PRE are each at least one cycle. They also assume that a full refresh cycle is shorter than REF_INTERVAL, and that the requester presents a request only while `req_ready_o` is high. The bench drives requests only at the falling edge after it has seen `req_ready_o` high, and it drops `req_valid_i` right after the accepting edge. Its memory model returns valid data only during the final column-access cycle, so a controller that samples early reads a garbage pattern.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW_SETUP,
    ST_ROW_ACT,
    ST_COL_ACT,
    ST_PRECHARGE,
    ST_REF_SETUP,
    ST_REF_ACT
  } mdc_state_e;

  function automatic int mdc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mdc_refresh_timer.sv
module mdc_refresh_timer #(
  parameter int REF_INTERVAL = 40,
  parameter int ROW_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_ack_i,
  input  logic             ref_done_i,
  output logic             ref_pend_o,
  output logic [ROW_W-1:0] ref_row_o
);
  localparam int IV_W = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;

  logic [IV_W-1:0]  iv_q, iv_d;
  logic             pend_q, pend_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             tick;

  always_comb begin
    tick   = (iv_q == '0);
    iv_d   = tick ? IV_W'(REF_INTERVAL - 1) : iv_q - 1'b1;
    pend_d = pend_q;
    if (tick)           pend_d = 1'b1;
    else if (ref_ack_i) pend_d = 1'b0;
    row_d  = row_q;
    if (ref_done_i)     row_d = row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv_q   <= IV_W'(REF_INTERVAL - 1);
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      iv_q   <= iv_d;
      pend_q <= pend_d;
      row_q  <= row_d;
    end
  end

  assign ref_pend_o = pend_q;
  assign ref_row_o  = row_q;
endmodule

// File: rtl/mdc_sequencer.sv
module mdc_sequencer
  import mdc_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8,
  parameter int T_RSU  = 1,
  parameter int T_RCD  = 2,
  parameter int T_CAC  = 2,
  parameter int T_PRE  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid_i,
  input  logic                   req_write_i,
  input  logic [ROW_W+COL_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  output logic                   req_ready_o,
  output logic [DATA_W-1:0]      rsp_rdata_o,
  output logic                   rsp_done_o,
  input  logic                   ref_pend_i,
  input  logic [ROW_W-1:0]       ref_row_i,
  output logic                   ref_ack_o,
  output logic                   ref_done_o,
  output logic [mdc_max(ROW_W, COL_W)-1:0] dram_addr_o,
  output logic                   dram_ras_o,
  output logic                   dram_cas_o,
  output logic                   dram_we_o,
  output logic [DATA_W-1:0]      dram_dq_o,
  output logic                   dram_dq_oe_o,
  input  logic [DATA_W-1:0]      dram_dq_i
);
  localparam int MA_W  = mdc_max(ROW_W, COL_W);
  localparam int AW    = ROW_W + COL_W;
  localparam int T_RAS = T_RCD + T_CAC;
  localparam int T_MAX = mdc_max(mdc_max(T_RSU, T_RAS), T_PRE);
  localparam int CNT_W = $clog2(T_MAX + 1);

  mdc_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              wr_q, done_q, done_d;
  logic              accept, capture, last;

  // next-state process
  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    done_d     = 1'b0;
    accept     = 1'b0;
    capture    = 1'b0;
    ref_ack_o  = 1'b0;
    ref_done_o = 1'b0;
    last       = (cnt_q == '0);
    if (!last) cnt_d = cnt_q - 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend_i) begin
          ref_ack_o = 1'b1;
          state_d   = ST_REF_SETUP;
          cnt_d     = CNT_W'(T_RSU - 1);
        end else if (req_valid_i) begin
          accept  = 1'b1;
          state_d = ST_ROW_SETUP;
          cnt_d   = CNT_W'(T_RSU - 1);
        end
      end
      ST_ROW_SETUP: if (last) begin
        state_d = ST_ROW_ACT;
        cnt_d   = CNT_W'(T_RCD - 1);
      end
      ST_ROW_ACT: if (last) begin
        state_d = ST_COL_ACT;
        cnt_d   = CNT_W'(T_CAC - 1);
      end
      ST_COL_ACT: if (last) begin
        state_d = ST_PRECHARGE;
        cnt_d   = CNT_W'(T_PRE - 1);
        done_d  = 1'b1;
        capture = !wr_q;
      end
      ST_REF_SETUP: if (last) begin
        state_d = ST_REF_ACT;
        cnt_d   = CNT_W'(T_RAS - 1);
      end
      ST_REF_ACT: if (last) begin
        state_d    = ST_PRECHARGE;
        cnt_d      = CNT_W'(T_PRE - 1);
        ref_done_o = 1'b1;
      end
      ST_PRECHARGE: if (last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        wr_q    <= req_write_i;
      end
      if (capture) rdata_q <= dram_dq_i;
    end
  end

  // pin drive
  logic user_wr_phase;
  always_comb begin
    dram_addr_o = '0;
    unique case (state_q)
      ST_ROW_SETUP, ST_ROW_ACT: dram_addr_o = MA_W'(addr_q[AW-1:COL_W]);
      ST_COL_ACT:               dram_addr_o = MA_W'(addr_q[COL_W-1:0]);
      ST_REF_SETUP, ST_REF_ACT: dram_addr_o = MA_W'(ref_row_i);
      default:                  dram_addr_o = '0;
    endcase
    user_wr_phase = wr_q && (state_q == ST_ROW_SETUP || state_q == ST_ROW_ACT ||
                             state_q == ST_COL_ACT);
  end

  assign dram_ras_o   = (state_q == ST_ROW_ACT) || (state_q == ST_COL_ACT) ||
                        (state_q == ST_REF_ACT);
  assign dram_cas_o   = (state_q == ST_COL_ACT);
  assign dram_we_o    = user_wr_phase;
  assign dram_dq_oe_o = user_wr_phase;
  assign dram_dq_o    = wdata_q;
  assign req_ready_o  = (state_q == ST_IDLE) && !ref_pend_i;
  assign rsp_rdata_o  = rdata_q;
  assign rsp_done_o   = done_q;
endmodule

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl
  import mdc_pkg::*;
#(
  parameter int ROW_W        = 4,
  parameter int COL_W        = 4,
  parameter int DATA_W       = 8,
  parameter int T_RSU        = 1,
  parameter int T_RCD        = 2,
  parameter int T_CAC        = 2,
  parameter int T_PRE        = 2,
  parameter int REF_INTERVAL = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid_i,
  input  logic                   req_write_i,
  input  logic [ROW_W+COL_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  output logic                   req_ready_o,
  output logic [DATA_W-1:0]      rsp_rdata_o,
  output logic                   rsp_done_o,
  output logic [mdc_max(ROW_W, COL_W)-1:0] dram_addr_o,
  output logic                   dram_ras_o,
  output logic                   dram_cas_o,
  output logic                   dram_we_o,
  output logic [DATA_W-1:0]      dram_dq_o,
  output logic                   dram_dq_oe_o,
  input  logic [DATA_W-1:0]      dram_dq_i
);
  logic             ref_pend, ref_ack, ref_done;
  logic [ROW_W-1:0] ref_row;

  mdc_refresh_timer #(
    .REF_INTERVAL(REF_INTERVAL),
    .ROW_W       (ROW_W)
  ) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_ack_i (ref_ack),
    .ref_done_i(ref_done),
    .ref_pend_o(ref_pend),
    .ref_row_o (ref_row)
  );

  mdc_sequencer #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W),
    .T_RSU (T_RSU),
    .T_RCD (T_RCD),
    .T_CAC (T_CAC),
    .T_PRE (T_PRE)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_ready_o (req_ready_o),
    .rsp_rdata_o (rsp_rdata_o),
    .rsp_done_o  (rsp_done_o),
    .ref_pend_i  (ref_pend),
    .ref_row_i   (ref_row),
    .ref_ack_o   (ref_ack),
    .ref_done_o  (ref_done),
    .dram_addr_o (dram_addr_o),
    .dram_ras_o  (dram_ras_o),
    .dram_cas_o  (dram_cas_o),
    .dram_we_o   (dram_we_o),
    .dram_dq_o   (dram_dq_o),
    .dram_dq_oe_o(dram_dq_oe_o),
    .dram_dq_i   (dram_dq_i)
  );
endmodule

// File: rtl/mdc_checker.sv
module mdc_checker #(
  parameter int T_PRE = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ras,
  input logic cas,
  input logic we,
  input logic oe,
  input logic ready,
  input logic done
);
  localparam int LC_W = $clog2(T_PRE + 2);
  logic [LC_W-1:0] low_cnt;

  // consecutive cycles with both strobes low, saturating at T_PRE
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      low_cnt <= LC_W'(T_PRE);
    else if (ras || cas)             low_cnt <= '0;
    else if (low_cnt < LC_W'(T_PRE)) low_cnt <= low_cnt + 1'b1;
  end

  assert_cas_under_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cas |-> ras);
  assert_ras_min_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras) |=> ras);
  assert_we_with_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> oe);
  assert_precharge_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras) |-> (low_cnt >= LC_W'(T_PRE)));
  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ras || cas || we) |-> !ready);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind mux_dram_ctrl mdc_checker #(.T_PRE(T_PRE)) chk_i (
  .clk  (clk),
  .rst_n(rst_n),
  .ras  (dram_ras_o),
  .cas  (dram_cas_o),
  .we   (dram_we_o),
  .oe   (dram_dq_oe_o),
  .ready(req_ready_o),
  .done (rsp_done_o)
);

// File: tb/mux_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module mux_dram_ctrl_tb_top;
  localparam int ROW_W = 4, COL_W = 4, DATA_W = 8;
  localparam int T_RSU = 1, T_RCD = 2, T_CAC = 2, T_PRE = 2, REF_INTERVAL = 40;
  localparam int LAT = T_RSU + T_RCD + T_CAC;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_ready, done, ras, cas, we, oe;
  logic [7:0] req_addr, req_wdata, rdata, dq_o, dq_i;
  logic [3:0] maddr;

  always #2 clk = ~clk;

  mux_dram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RSU(T_RSU), .T_RCD(T_RCD),
    .T_CAC(T_CAC), .T_PRE(T_PRE), .REF_INTERVAL(REF_INTERVAL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .rsp_rdata_o(rdata), .rsp_done_o(done), .dram_addr_o(maddr), .dram_ras_o(ras),
    .dram_cas_o(cas), .dram_we_o(we), .dram_dq_o(dq_o), .dram_dq_oe_o(oe),
    .dram_dq_i(dq_i)
  );

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem [0:255];
  int  cyc = 0, ras_run = 0, cas_run = 0, low_run = 100;
  int  ref_count = 0, last_ref_rise = 0, ras_rise_cyc = 0, ref_wraps = 0;
  bit  ras_p = 0, cas_p = 0, cas_seen = 0, user_active = 0, cyc_user = 0;
  logic [3:0] row_m = '0, col_m = '0, exp_row = '0, exp_col = '0, exp_ref_row = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      dq_i = 8'hE7;
    end else begin
      cyc++;
      if (ras && !ras_p) begin
        row_m        = maddr;
        ras_rise_cyc = cyc;
        cas_seen     = 0;
        cyc_user     = user_active;
        chk(low_run >= T_PRE, "R6 precharge gap", low_run, T_PRE);
        chk(!req_ready, "R9 ready low while active", req_ready, 0);
        if (cyc_user) chk(maddr == exp_row, "R1 row on pins", maddr, exp_row);
      end
      if (cas && !cas_p) begin
        col_m    = maddr;
        cas_seen = 1;
        chk(cyc_user, "R3 column strobe only on user cycle", cyc_user, 1);
        chk(cyc - ras_rise_cyc == T_RCD, "R2 ras-to-cas", cyc - ras_rise_cyc, T_RCD);
        chk(maddr == exp_col, "R1 column on pins", maddr, exp_col);
        if (we) mem[{row_m, col_m}] = dq_o;
      end
      if (!ras && ras_p && !cas_seen) begin
        chk(!cyc_user, "R7 refresh not during user cycle", cyc_user, 0);
        chk(row_m == exp_ref_row, "R8 refresh row", row_m, exp_ref_row);
        chk(ras_run == T_RCD + T_CAC, "R7 refresh ras width", ras_run, T_RCD + T_CAC);
        if (exp_ref_row == 4'hF) ref_wraps++;
        exp_ref_row   = exp_ref_row + 1'b1;
        last_ref_rise = ras_rise_cyc;
        ref_count++;
      end
      if (!ras && ras_p && cas_seen)
        chk(cas_run == T_CAC, "R3 cas width", cas_run, T_CAC);
      ras_run = ras ? ras_run + 1 : (ras_p ? ras_run : 0);
      if (ras && !ras_p) ras_run = 1;
      if (cas) cas_run = cas_p ? cas_run + 1 : 1;
      low_run = (ras || cas) ? 0 : low_run + 1;
      // valid data only in the final column-access cycle
      dq_i = (cas && cas_run == T_CAC) ? mem[{row_m, col_m}] : 8'hE7;
      ras_p = ras;
      cas_p = cas;
    end
  end

  // ---------------- tasks ----------------
  task automatic access(input bit wr, input logic [7:0] a, input logic [7:0] wd,
                        output logic [7:0] rd);
    int lat;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    exp_row = a[7:4]; exp_col = a[3:0]; user_active = 1;
    @(posedge clk);
    #1 req_valid = 0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1 && wr) begin
        chk(we && oe, "R5 write enable from first cycle", {we, oe}, 3);
        chk(dq_o == wd, "R5 write data driven", dq_o, wd);
      end
    end while (!done && lat < 100);
    chk(lat == LAT + 1, "R10 done latency", lat, LAT + 1);
    rd = rdata;
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
    user_active = 0;
  endtask

  task automatic t_reset();
    chk(!ras && !cas && !we && !oe && !done, "R11 strobes low in reset",
        {ras, cas, we, oe, done}, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(!ras && !cas && !we && !oe && !done, "R11 strobes low after reset",
        {ras, cas, we, oe, done}, 0);
    chk(req_ready, "R11 ready after reset", req_ready, 1);
  endtask

  task automatic t_patterns();
    logic [7:0] addrs [6] = '{8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h10, 8'h01};
    logic [7:0] rd;
    foreach (addrs[i]) access(1, addrs[i], 8'h11 * (i + 1) ^ 8'h80, rd);
    foreach (addrs[i]) begin
      access(0, addrs[i], 8'h00, rd);
      chk(rd == (8'h11 * (i + 1) ^ 8'h80), "R4 read back", rd, 8'h11 * (i + 1) ^ 8'h80);
    end
    access(0, 8'h37, 8'h00, rd);
    chk(rd == (8'h37 ^ 8'h3C), "R4 read untouched word", rd, 8'h37 ^ 8'h3C);
    access(1, 8'h38, 8'h99, rd);
    chk(rdata == (8'h37 ^ 8'h3C), "R4 read data held over write", rdata, 8'h37 ^ 8'h3C);
  endtask

  task automatic t_refresh_idle();
    int r0, t1, t2;
    r0 = ref_count;
    while (ref_count < r0 + 1) @(negedge clk);
    t1 = last_ref_rise;
    while (ref_count < r0 + 2) @(negedge clk);
    t2 = last_ref_rise;
    chk(t2 - t1 == REF_INTERVAL, "R7 refresh interval", t2 - t1, REF_INTERVAL);
    while (ref_count < r0 + 18) @(negedge clk);
    chk(ref_wraps >= 1, "R8 refresh row wrap", ref_wraps, 1);
  endtask

  task automatic t_back_to_back();
    int r0;
    logic [7:0] rd, a, d;
    r0 = ref_count;
    for (int i = 0; i < 40; i++) begin
      a = 8'(i * 37 + 5); d = 8'(i * 91 + 3);
      access(1, a, d, rd);
      access(0, a, 8'h00, rd);
      chk(rd == d, "R9 read under refresh load", rd, d);
    end
    chk(ref_count > r0 + 3, "R9 refresh not starved", ref_count - r0, r0 + 4);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;
    repeat (3) @(negedge clk);
    t_reset();
    t_patterns();
    t_refresh_idle();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule